// File: doc/BRIEF.md
# Scan Shift Power Estimator

This block estimates how much switching one scan chain causes while a test pattern is shifted in and the previous pattern's captured response is shifted out. Each transition between neighbouring bits is weighted by how many cells it will ripple through, and the weights are summed. The chain has `CELLS` cells, where cell 1 is fed by the scan input and indices grow away from it. The pattern takes `SHIFTS` shift cycles, with `SHIFTS` never below `CELLS`.

A caller presents the captured response vector and the full stimulus stream as parallel words and pulses `start_i`. The block copies both words, then walks one weighted term per clock. When the walk ends it raises `done_o`, holds the total, and flags `reject_o` if the total is above a programmable limit. Setting `accum_i` on a start adds the new chain onto the held total, so the figure for a whole design can be built one chain at a time.

Top module: `shift_power_est`

## Requirements
- R1: After synchronous reset, `total_o`, `done_o`, `reject_o` and `busy_o` are all 0.
- R2: Response bit `resp_i[i-1]` is cell i. A difference between cells i-1 and i, for i in 2..CELLS, adds CELLS-i+1 to the total.
- R3: Stimulus bit `stim_i[j-1]` is stimulus bit j. A difference between the last stimulus bit (j = SHIFTS) and response cell 1 adds CELLS.
- R4: A difference between stimulus bits j-1 and j, for j in CELLS+1..SHIFTS, adds CELLS.
- R5: A difference between stimulus bits j-1 and j, for j in 2..CELLS, adds j-1.
- R6: `done_o` goes high on the (SHIFTS+CELLS)-th rising edge after the edge that accepts `start_i`. It stays high, with `total_o` unchanged, until the next accepted start, which clears it.
- R7: A start with `accum_i`=1 adds the new chain's sum to the held total. A start with `accum_i`=0 begins again from 0.
- R8: When `done_o` rises, `reject_o` is 1 exactly when the total is strictly greater than `thr_i`.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The running result and its latency do not change, even if the data inputs change.
- R10: Equal bits everywhere give a sum of 0. Fully alternating vectors whose last stimulus bit differs from cell 1 give the maximum, SHIFTS*CELLS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| accum_i | input | 1 | 1: add onto the held total; 0: restart from 0 |
| resp_i | input | CELLS | Captured response, bit i-1 = cell i |
| stim_i | input | SHIFTS | Stimulus stream, bit j-1 = stimulus bit j |
| thr_i | input | TOT_W | Reject threshold |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Result valid and held |
| total_o | output | TOT_W | Weighted transition total |
| reject_o | output | 1 | Total exceeded the threshold |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a walk with new data on the inputs. The block must ignore it: the copied vectors stay in use and the latency stays the same. The bench injects such a pulse a few cycles into a maximum-weight run, and drives the data buses to zero at the same moment. Each region weight is isolated by vectors that contain a single flipped bit. The two threshold checks sit one apart around the same total, which pins down the strict comparison.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned WT_W = 16;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        RG_RESP,
        RG_EDGE,
        RG_TAIL,
        RG_BODY
    } region_e;

    typedef struct packed {
        region_e           region;
        logic              flip;
        logic [WT_W-1:0]   weight;
    } term_t;

    // Which part of the sum term index k belongs to.
    function automatic region_e region_of(input int k, input int cells, input int shifts);
        if (k < cells - 1)       return RG_RESP;
        else if (k == cells - 1) return RG_EDGE;
        else if (k < shifts)     return RG_TAIL;
        else                     return RG_BODY;
    endfunction

endpackage

// File: rtl/ssp_seq.sv
module ssp_seq
    import ssp_pkg::*;
#(
    parameter int unsigned CELLS  = 8,
    parameter int unsigned SHIFTS = 12,
    parameter int unsigned IDX_W  = $clog2(SHIFTS + CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             launch_o,
    output logic             add_en_o,
    output logic             fin_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SHIFTS + CELLS - 2);

    seq_state_e state_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (start_i) begin
                    state_q <= SQ_RUN;
                    idx_q   <= '0;
                end
                SQ_RUN: if (idx_q == LAST_IDX) state_q <= SQ_FIN;
                        else                   idx_q   <= idx_q + 1'b1;
                SQ_FIN:  state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign launch_o = (state_q == SQ_IDLE) && start_i;
    assign add_en_o = (state_q == SQ_RUN);
    assign fin_o    = (state_q == SQ_FIN);
    assign busy_o   = (state_q != SQ_IDLE);
    assign idx_o    = idx_q;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        add_en_o |-> idx_o <= LAST_IDX);                                        // R6
    AST_FIN_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(fin_o) |-> $past(add_en_o) && $past(idx_o) == LAST_IDX);          // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (add_en_o && idx_o != LAST_IDX) |=> add_en_o && idx_o == $past(idx_o) + 1'b1); // R9

endmodule

// File: rtl/ssp_term_sel.sv
module ssp_term_sel
    import ssp_pkg::*;
#(
    parameter int unsigned CELLS  = 8,
    parameter int unsigned SHIFTS = 12,
    parameter int unsigned IDX_W  = $clog2(SHIFTS + CELLS)
) (
    input  logic [CELLS-1:0]  resp_i,
    input  logic [SHIFTS-1:0] stim_i,
    input  logic [IDX_W-1:0]  idx_i,
    output term_t             term_o
);

    int k;
    logic [CELLS-1:0]  rsh;
    logic [SHIFTS-1:0] ssh;

    always_comb begin
        k      = int'(idx_i);
        rsh    = '0;
        ssh    = '0;
        term_o = '0;
        term_o.region = region_of(k, CELLS, SHIFTS);
        unique case (term_o.region)
            RG_RESP: begin
                rsh           = resp_i >> k;
                term_o.flip   = rsh[0] ^ rsh[1];
                term_o.weight = WT_W'(CELLS - 1 - k);
            end
            RG_EDGE: begin
                term_o.flip   = stim_i[SHIFTS-1] ^ resp_i[0];
                term_o.weight = WT_W'(CELLS);
            end
            RG_TAIL: begin
                ssh           = stim_i >> (k - 1);
                term_o.flip   = ssh[0] ^ ssh[1];
                term_o.weight = WT_W'(CELLS);
            end
            default: begin
                ssh           = stim_i >> (k - SHIFTS);
                term_o.flip   = ssh[0] ^ ssh[1];
                term_o.weight = WT_W'(k - SHIFTS + 1);
            end
        endcase
    end

endmodule

// File: rtl/ssp_accum.sv
module ssp_accum
    import ssp_pkg::*;
#(
    parameter int unsigned CELLS = 8,
    parameter int unsigned TOT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic             accum_i,
    input  logic             add_en_i,
    input  logic             fin_i,
    input  term_t            term_i,
    input  logic [TOT_W-1:0] thr_i,
    output logic [TOT_W-1:0] total_o,
    output logic             done_o,
    output logic             reject_o
);

    logic [TOT_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            done_o   <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            if (launch_i) begin
                done_o <= 1'b0;
                if (!accum_i) acc_q <= '0;
            end else if (add_en_i && term_i.flip) begin
                acc_q <= acc_q + TOT_W'(term_i.weight);
            end
            if (fin_i) begin
                done_o   <= 1'b1;
                reject_o <= (acc_q > thr_i);
            end
        end
    end

    assign total_o = acc_q;

    AST_WEIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
        add_en_i |-> term_i.weight <= WT_W'(CELLS));                            // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        add_en_i |=> total_o >= $past(total_o));                                // R7
    AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
        (launch_i && !accum_i) |=> total_o == '0);                              // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done_o && !launch_i) |=> done_o && $stable(total_o));                  // R6
    AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        launch_i |=> !done_o);                                                  // R6
    AST_REJECT_STRICT: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> reject_o == (total_o > $past(thr_i)));                // R8

endmodule

// File: rtl/shift_power_est.sv
module shift_power_est
    import ssp_pkg::*;
#(
    parameter int unsigned CELLS      = 8,
    parameter int unsigned SHIFTS     = 12,
    parameter int unsigned MAX_CHAINS = 4,
    parameter int unsigned TOT_W      = $clog2(MAX_CHAINS * SHIFTS * CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              accum_i,
    input  logic [CELLS-1:0]  resp_i,
    input  logic [SHIFTS-1:0] stim_i,
    input  logic [TOT_W-1:0]  thr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [TOT_W-1:0]  total_o,
    output logic              reject_o
);

    localparam int unsigned IDX_W = $clog2(SHIFTS + CELLS);

    logic              launch, add_en, fin;
    logic [IDX_W-1:0]  idx;
    logic [CELLS-1:0]  resp_q;
    logic [SHIFTS-1:0] stim_q;
    term_t             term;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
            stim_q <= '0;
        end else if (launch) begin
            resp_q <= resp_i;
            stim_q <= stim_i;
        end
    end

    ssp_seq #(.CELLS(CELLS), .SHIFTS(SHIFTS), .IDX_W(IDX_W)) seq_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .launch_o(launch), .add_en_o(add_en), .fin_o(fin),
        .busy_o(busy_o), .idx_o(idx)
    );

    ssp_term_sel #(.CELLS(CELLS), .SHIFTS(SHIFTS), .IDX_W(IDX_W)) sel_i (
        .resp_i(resp_q), .stim_i(stim_q), .idx_i(idx), .term_o(term)
    );

    ssp_accum #(.CELLS(CELLS), .TOT_W(TOT_W)) acc_i (
        .clk(clk), .rst(rst), .launch_i(launch), .accum_i(accum_i),
        .add_en_i(add_en), .fin_i(fin), .term_i(term), .thr_i(thr_i),
        .total_o(total_o), .done_o(done_o), .reject_o(reject_o)
    );

    AST_COPY_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(resp_q) && $stable(stim_q));                         // R9

endmodule

// File: tb/shift_power_est_tb_top.sv
module shift_power_est_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int C = 8;
    localparam int S = 12;
    localparam int TW = 9;
    localparam int NV = 12;

    typedef struct packed {
        logic [C-1:0]  r;
        logic [S-1:0]  s;
        logic          acc;
        logic [TW-1:0] thr;
        logic [TW-1:0] exp_tot;
        logic          exp_rej;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{8'h00, 12'h000, 1'b0, 9'd0,   9'd0,   1'b0},  // R10 all zero
        '{8'h00, 12'h800, 1'b0, 9'd20,  9'd16,  1'b0},  // R4 last stim bit: edge + tail
        '{8'h01, 12'h000, 1'b0, 9'd10,  9'd15,  1'b1},  // R2 cell1: resp 7 + edge 8
        '{8'h00, 12'h001, 1'b0, 9'd0,   9'd1,   1'b1},  // R5 first stim bit: weight 1
        '{8'hAA, 12'hAAA, 1'b0, 9'd95,  9'd96,  1'b1},  // R10 maximum S*C
        '{8'hAA, 12'hAAA, 1'b0, 9'd96,  9'd96,  1'b0},  // R8 equal is not over
        '{8'h00, 12'h800, 1'b1, 9'd100, 9'd112, 1'b1},  // R7 96 + 16
        '{8'hFF, 12'hFFF, 1'b0, 9'd0,   9'd0,   1'b0},  // R10 all ones
        '{8'hFF, 12'h000, 1'b0, 9'd8,   9'd8,   1'b0},  // R3 only the edge flips
        '{8'h80, 12'h000, 1'b0, 9'd0,   9'd1,   1'b1},  // R2 cell 8: weight 1
        '{8'h40, 12'h000, 1'b0, 9'd2,   9'd3,   1'b1},  // R2 cell 7: 2 + 1
        '{8'h00, 12'h080, 1'b0, 9'd15,  9'd15,  1'b0}   // R5 stim bit 8: body 7 + tail 8
    };
    string tags [NV] = '{"R10", "R4", "R2", "R5", "R10", "R8",
                         "R7", "R10", "R3", "R2", "R2", "R5"};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          accum_i = 1'b0;
    logic [C-1:0]  resp_i = '0;
    logic [S-1:0]  stim_i = '0;
    logic [TW-1:0] thr_i = '0;
    logic          busy_o, done_o, reject_o;
    logic [TW-1:0] total_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_power_est dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .accum_i(accum_i),
        .resp_i(resp_i), .stim_i(stim_i), .thr_i(thr_i),
        .busy_o(busy_o), .done_o(done_o), .total_o(total_o), .reject_o(reject_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_chain(input logic [C-1:0] r, input logic [S-1:0] s,
                             input logic acc, input logic [TW-1:0] thr,
                             input int inject_at, output int lat);
        @(negedge clk);
        resp_i = r; stim_i = s; accum_i = acc; thr_i = thr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
            start_i = 1'b0;
            if (lat == inject_at) begin
                start_i = 1'b1; resp_i = '0; stim_i = '0; accum_i = 1'b0;
            end
        end
        if (lat >= 200) check("R6 timeout", lat, S + C);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 total", int'(total_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 reject", int'(reject_o), 0);
        check("R1 busy", int'(busy_o), 0);

        for (int v = 0; v < NV; v++) begin
            run_chain(TBL[v].r, TBL[v].s, TBL[v].acc, TBL[v].thr, 0, lat);
            check(tags[v], int'(total_o), int'(TBL[v].exp_tot));
            check("R8 reject", int'(reject_o), int'(TBL[v].exp_rej));
            if (v == 0) check("R6 latency", lat, S + C);
        end

        // R9: start pulse with zeroed data in the middle of a maximum run
        run_chain(8'hAA, 12'hAAA, 1'b0, 9'd0, 5, lat);
        check("R9 total", int'(total_o), 96);
        check("R9 latency", lat, S + C);

        // R6: result and done held over idle cycles
        held = int'(total_o);
        repeat (6) @(negedge clk);
        check("R6 done held", int'(done_o), 1);
        check("R6 total held", int'(total_o), held);
        check("R6 busy after", int'(busy_o), 0);

        // R1: reset after a nonzero result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 total after", int'(total_o), 0);
        check("R1 done after", int'(done_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule